// File: doc/BRIEF.md
# Polled Byte Port Controller

This block sits on the device side of a byte-wide port and is reached by a host through four word-addressed registers: a receive data register, a transmit data register, a status register and a command/control register. The host drives output with a two-flag handshake. It loads the transmit byte, then writes the command register with the go flag set (and the write flag for a transfer). The controller raises busy, decodes the command, offers the byte on a ready/valid device interface, and on completion clears go, error and busy in a single step.

Bytes from the device enter a small receive FIFO that sits behind the receive data register. The FIFO absorbs bursts until the host reads them, and each read of that register pops one byte. Mode fields in the control register (duplex, parity enable, speed code) are only captured and driven out as pins. If the device does not take a byte within a fixed cycle budget, the transfer is abandoned and error is raised. An overrun of the receive FIFO also raises error.

Top module: `pio_port_ctrl`

## Requirements
- R1: The host reads offset 0 as the oldest receive byte, offset 1 as the transmit byte, offset 2 as status (bit 0 busy, bit 1 data available, bit 2 error, other bits 0) and offset 3 as control (bit 0 go, bit 1 write, bit 2 full duplex, bit 3 parity enable, bits 6:4 speed code, bit 7 reads 0). After reset all of these read 0.
- R2: Busy rises on the clock edge after the edge that stores go=1, and the device valid is never high unless busy is high.
- R3: For a command with go=1 and write=1, the transmit byte appears on the device data output with valid high one cycle after busy rises. Valid and the data are held until the device signals ready.
- R4: On the edge where the device accepts the byte, go, error and busy all return to 0 and valid drops.
- R5: A host write to offset 1 or offset 3 while busy is high changes neither register, so the byte being sent and the mode outputs stay the same.
- R6: If ready stays low, valid is held for exactly TIMEOUT_CYC (default 256) cycles and then dropped. On that edge error is set and go and busy are cleared.
- R7: A command with go=1 and write=0 finishes with no device transfer. It clears error and go and leaves busy low within three cycles of the write.
- R8: The mode outputs follow the control fields given in R1, as stored by the last control write accepted while not busy.
- R9: Received bytes are read back in arrival order. Data available is high exactly while the FIFO holds a byte, and each read of offset 0 removes one byte.
- R10: A byte that arrives while the FIFO already holds DEPTH (default 4) bytes is discarded, and error is set.
- R11: Reading offset 0 with the FIFO empty returns 0 and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register word offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops on offset 0) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read data for host_addr |
| dev_tx_data | output | 8 | Byte offered to the device |
| dev_tx_valid | output | 1 | Byte on dev_tx_data is valid |
| dev_tx_ready | input | 1 | Device accepts the byte |
| dev_rx_data | input | 8 | Byte from the device |
| dev_rx_valid | input | 1 | Byte from the device is present this cycle |
| mode_full_duplex | output | 1 | Stored duplex selection |
| mode_parity_en | output | 1 | Stored parity-check enable |
| mode_speed | output | 3 | Stored speed code |

## Verification
On every cycle, the assertions check that valid appears only under busy and that an offered byte stays steady while the device stalls. They also check that the stall never exceeds the timeout budget, that busy never falls with go still set, that writes made while busy leave the transmit register alone, and that an overrun always leaves error set. The exact cycle on which busy rises and valid appears can only be shown by the directed scenarios. The same holds for the value error ends with after a success, a timeout or a no-op command, for the arrival order of FIFO bytes, and for the read of an empty data register.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        REG_RXDATA = 2'd0,
        REG_TXDATA = 2'd1,
        REG_STATUS = 2'd2,
        REG_CTRL   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       rsvd;
        logic [2:0] speed;
        logic       parity_en;
        logic       full_duplex;
        logic       write;
        logic       go;
    } ctrl_t;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       err;
        logic       data_avail;
        logic       busy;
    } status_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_XFER   = 2'd2
    } cmd_state_e;

    function automatic ctrl_t ctrl_from_bus(input logic [7:0] v);
        ctrl_t c;
        c      = ctrl_t'(v);
        c.rsvd = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pio_rx_fifo.sv
module pio_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             overrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign overrun = push && full;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= '0;
                else if (do_push && wr_ptr == PW'(i))
                    mem[i] <= push_data;
            end
        end
    endgenerate

endmodule

// File: rtl/pio_cmd_fsm.sv
module pio_cmd_fsm
    import pio_pkg::*;
#(
    parameter int TIMEOUT_CYC = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic write,
    input  logic dev_ready,
    output logic busy,
    output logic tx_valid,
    output logic done_ok,
    output logic done_timeout
);
    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

    cmd_state_e    state, state_nx;
    logic [CW-1:0] wait_cnt;
    logic          last_wait;

    assign busy      = (state != ST_IDLE);
    assign tx_valid  = (state == ST_XFER);
    assign last_wait = (wait_cnt == CW'(TIMEOUT_CYC - 1));

    always_comb begin
        state_nx     = state;
        done_ok      = 1'b0;
        done_timeout = 1'b0;
        case (state)
            ST_IDLE: begin
                if (go) state_nx = ST_DECODE;
            end
            ST_DECODE: begin
                if (write) begin
                    state_nx = ST_XFER;
                end else begin
                    state_nx = ST_IDLE;
                    done_ok  = 1'b1;
                end
            end
            ST_XFER: begin
                if (dev_ready) begin
                    state_nx = ST_IDLE;
                    done_ok  = 1'b1;
                end else if (last_wait) begin
                    state_nx     = ST_IDLE;
                    done_timeout = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_XFER && state_nx == ST_XFER)
                wait_cnt <= wait_cnt + 1'b1;
            else
                wait_cnt <= '0;
        end
    end

endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       busy,
    input  logic       done_ok,
    input  logic       done_timeout,
    input  logic       rx_overrun,
    input  logic       rx_empty,
    input  logic [7:0] rx_head,
    output ctrl_t      ctrl_q,
    output logic [7:0] dout_q,
    output logic       err_q
);
    reg_addr_e addr;
    status_t   stat;
    logic      wr_dout, wr_ctrl;

    assign addr    = reg_addr_e'(host_addr);
    assign wr_dout = host_wr && !busy && (addr == REG_TXDATA);
    assign wr_ctrl = host_wr && !busy && (addr == REG_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            ctrl_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_dout) dout_q <= host_wdata;
            if (wr_ctrl)
                ctrl_q <= ctrl_from_bus(host_wdata);
            else if (done_ok || done_timeout)
                ctrl_q.go <= 1'b0;
            if (rx_overrun || done_timeout)
                err_q <= 1'b1;
            else if (done_ok)
                err_q <= 1'b0;
        end
    end

    always_comb begin
        stat            = '0;
        stat.busy       = busy;
        stat.data_avail = !rx_empty;
        stat.err        = err_q;
        case (addr)
            REG_RXDATA: host_rdata = rx_empty ? 8'h00 : rx_head;
            REG_TXDATA: host_rdata = dout_q;
            REG_STATUS: host_rdata = stat;
            REG_CTRL:   host_rdata = ctrl_q;
            default:    host_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
    import pio_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int TIMEOUT_CYC = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic [7:0] dev_tx_data,
    output logic       dev_tx_valid,
    input  logic       dev_tx_ready,
    input  logic [7:0] dev_rx_data,
    input  logic       dev_rx_valid,
    output logic       mode_full_duplex,
    output logic       mode_parity_en,
    output logic [2:0] mode_speed
);
    ctrl_t      ctrl_q;
    logic [7:0] dout_val;
    logic       err_flag;
    logic       busy, done_ok, done_timeout;
    logic       fifo_empty, fifo_full, fifo_overrun, fifo_pop;
    logic [7:0] fifo_head;
    logic       go_flag;

    assign go_flag  = ctrl_q.go;
    assign fifo_pop = host_rd && (reg_addr_e'(host_addr) == REG_RXDATA);

    pio_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (dev_rx_valid),
        .push_data (dev_rx_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .overrun   (fifo_overrun)
    );

    pio_cmd_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .go           (ctrl_q.go),
        .write        (ctrl_q.write),
        .dev_ready    (dev_tx_ready),
        .busy         (busy),
        .tx_valid     (dev_tx_valid),
        .done_ok      (done_ok),
        .done_timeout (done_timeout)
    );

    pio_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .host_addr    (host_addr),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .busy         (busy),
        .done_ok      (done_ok),
        .done_timeout (done_timeout),
        .rx_overrun   (fifo_overrun),
        .rx_empty     (fifo_empty),
        .rx_head      (fifo_head),
        .ctrl_q       (ctrl_q),
        .dout_q       (dout_val),
        .err_q        (err_flag)
    );

    assign dev_tx_data      = dout_val;
    assign mode_full_duplex = ctrl_q.full_duplex;
    assign mode_parity_en   = ctrl_q.parity_en;
    assign mode_speed       = ctrl_q.speed;

endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
    parameter int TIMEOUT_CYC = 256
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       go_flag,
    input logic       err_flag,
    input logic [7:0] dout_val,
    input logic       host_wr,
    input logic [1:0] host_addr,
    input logic       dev_tx_valid,
    input logic       dev_tx_ready,
    input logic [7:0] dev_tx_data,
    input logic       dev_rx_valid,
    input logic       fifo_full
);
    localparam int SW = $clog2(TIMEOUT_CYC + 1) + 1;
    logic [SW-1:0] stall_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            stall_cnt <= '0;
        else if (dev_tx_valid && !dev_tx_ready)
            stall_cnt <= stall_cnt + 1'b1;
        else
            stall_cnt <= '0;
    end

    AST_VALID_UNDER_BUSY: assert property (@(posedge clk) disable iff (rst)
        dev_tx_valid |-> busy); // R2

    AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
        (dev_tx_valid && !dev_tx_ready && stall_cnt < SW'(TIMEOUT_CYC - 1))
        |=> (dev_tx_valid && $stable(dev_tx_data))); // R3

    AST_GO_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !go_flag); // R4

    AST_NO_TXWRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr && host_addr == 2'd1) |=> $stable(dout_val)); // R5

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
        dev_tx_valid |-> (stall_cnt < SW'(TIMEOUT_CYC))); // R6

    AST_OVERRUN_ERR: assert property (@(posedge clk) disable iff (rst)
        (dev_rx_valid && fifo_full) |=> err_flag); // R10

endmodule

bind pio_port_ctrl pio_port_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .go_flag      (go_flag),
    .err_flag     (err_flag),
    .dout_val     (dout_val),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .dev_tx_valid (dev_tx_valid),
    .dev_tx_ready (dev_tx_ready),
    .dev_tx_data  (dev_tx_data),
    .dev_rx_valid (dev_rx_valid),
    .fifo_full    (fifo_full)
);

// File: tb/test_pio_port_ctrl.sv
module test_pio_port_ctrl;
    localparam int DEPTH = 4;
    localparam int TMO   = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] dev_tx_data;
    logic       dev_tx_valid;
    logic       dev_tx_ready = 1'b0;
    logic [7:0] dev_rx_data = '0;
    logic       dev_rx_valid = 1'b0;
    logic       mode_full_duplex, mode_parity_en;
    logic [2:0] mode_speed;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pio_port_ctrl #(.FIFO_DEPTH(DEPTH), .TIMEOUT_CYC(TMO)) i_pio_port_ctrl (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_tx_data(dev_tx_data), .dev_tx_valid(dev_tx_valid),
        .dev_tx_ready(dev_tx_ready), .dev_rx_data(dev_rx_data),
        .dev_rx_valid(dev_rx_valid), .mode_full_duplex(mode_full_duplex),
        .mode_parity_en(mode_parity_en), .mode_speed(mode_speed)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FIFO-PORT FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1;
        d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 600; i++) begin
            peek(2'd2, s);
            if (!s[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            peek(a[1:0], v);
            check("R1 reset register", v, 0);
        end
        check("R3 reset valid", dev_tx_valid, 0);
        check("R8 reset modes", {mode_full_duplex, mode_parity_en, mode_speed}, 0);
    endtask

    task automatic t_write_cmd();
        logic [7:0] v;
        dev_tx_ready = 1'b1;
        wr(2'd1, 8'hA5);
        peek(2'd1, v);
        check("R1 txdata readback", v, 8'hA5);
        wr(2'd3, 8'h5F);
        peek(2'd2, v);
        check("R2 busy still low right after write", v[0], 0);
        @(negedge clk);
        peek(2'd2, v);
        check("R2 busy one edge after go", v[0], 1);
        check("R2 no valid yet", dev_tx_valid, 0);
        @(negedge clk);
        check("R3 valid after decode", dev_tx_valid, 1);
        check("R3 tx data", dev_tx_data, 8'hA5);
        @(negedge clk);
        peek(2'd2, v);
        check("R4 status after accept", v, 0);
        check("R4 valid dropped", dev_tx_valid, 0);
        peek(2'd3, v);
        check("R4 go cleared, fields kept", v, 8'h5E);
        check("R8 duplex", mode_full_duplex, 1);
        check("R8 parity", mode_parity_en, 1);
        check("R8 speed", mode_speed, 5);
    endtask

    task automatic t_ignore_busy();
        logic [7:0] v;
        dev_tx_ready = 1'b0;
        wr(2'd1, 8'h3C);
        wr(2'd3, 8'h23);
        for (int i = 0; i < 4 && !dev_tx_valid; i++) @(negedge clk);
        check("R3 valid while stalled", dev_tx_valid, 1);
        wr(2'd1, 8'hFF);
        wr(2'd3, 8'h70);
        peek(2'd1, v);
        check("R5 txdata unchanged", v, 8'h3C);
        check("R5 tx data held", dev_tx_data, 8'h3C);
        check("R5 speed unchanged", mode_speed, 2);
        peek(2'd3, v);
        check("R5 ctrl unchanged", v, 8'h23);
        dev_tx_ready = 1'b1;
        @(negedge clk);
        peek(2'd2, v);
        check("R4 done after late ready", v, 0);
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        int n;
        dev_tx_ready = 1'b0;
        wr(2'd1, 8'h11);
        wr(2'd3, 8'h03);
        for (int i = 0; i < 4 && !dev_tx_valid; i++) @(negedge clk);
        n = 0;
        while (dev_tx_valid && n < TMO + 10) begin
            n++;
            @(negedge clk);
        end
        check("R6 valid cycles", n, TMO);
        peek(2'd2, v);
        check("R6 status err set busy clear", v, 8'h04);
        peek(2'd3, v);
        check("R6 go cleared", v[0], 0);
    endtask

    task automatic t_nowrite();
        logic [7:0] v;
        int seen;
        seen = 0;
        wr(2'd3, 8'h01);
        for (int i = 0; i < 4; i++) begin
            if (dev_tx_valid) seen++;
            @(negedge clk);
        end
        check("R7 no transfer", seen, 0);
        peek(2'd2, v);
        check("R7 err cleared and idle", v, 0);
        peek(2'd3, v);
        check("R7 go cleared", v[0], 0);
    endtask

    task automatic push_bytes(input int n, input logic [7:0] base);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            dev_rx_valid = 1'b1;
            dev_rx_data  = base + 8'(i);
            @(negedge clk);
        end
        dev_rx_valid = 1'b0;
    endtask

    task automatic t_fifo();
        logic [7:0] v;
        push_bytes(3, 8'h40);
        peek(2'd2, v);
        check("R9 data available", v[1], 1);
        for (int i = 0; i < 3; i++) begin
            rd(2'd0, v);
            check("R9 order", v, 8'h40 + i);
        end
        peek(2'd2, v);
        check("R9 data available low", v[1], 0);
        rd(2'd0, v);
        check("R11 empty read", v, 0);
        push_bytes(1, 8'h77);
        rd(2'd0, v);
        check("R11 nothing removed by empty read", v, 8'h77);
        peek(2'd2, v);
        check("R9 err untouched by normal traffic", v, 0);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        push_bytes(DEPTH + 1, 8'h90);
        peek(2'd2, v);
        check("R10 error on overrun", v[2], 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd(2'd0, v);
            check("R10 kept bytes", v, 8'h90 + i);
        end
        peek(2'd2, v);
        check("R10 extra byte dropped", v[1], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_cmd();
        wait_idle();
        t_ignore_busy();
        wait_idle();
        t_timeout();
        t_nowrite();
        t_fifo();
        t_overflow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FIFO-PORT FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule